// File: doc/BRIEF.md
# Asynchronous Parallel Flash Bus Controller

This block sits on the host side of an asynchronous parallel NOR-style memory. It takes one request at a time over a valid/ready handshake and turns it into properly ordered chip-enable, write-enable and output-enable strobes, an address, and a data bus split into output, output enable and input. It supports three kinds of request: a single-word read, a four-word page read and a single write to the memory's command interface.

Every wait is a parameter counted in clock cycles: the read access time, the page access time, the write pulse width and the recovery time between operations. Outside a transfer the memory is held in standby with all three strobes high and the data bus released. For a write, chip enable falls first and write enable falls one cycle later, so the memory latches the address on the write-enable edge. Write enable then rises one cycle before chip enable, so the data is captured while it is still driven. A page read opens the page once, then steps only the two lowest address bits while the strobes stay low.

Top module: `flash_bus_ctl`

## Requirements
- R1: After reset and whenever no request is in progress, chip enable, write enable and output enable are all high (inactive), the data output enable is low and `req_ready_o` is high.
- R2: A read with the page flag low presents the address and pulls chip enable and output enable low together, with write enable high, for exactly T_ACC cycles. It then returns the word on `rsp_data_o` with one `rsp_valid_o` pulse, visible T_ACC+1 cycles after the accepting clock edge.
- R3: A write pulls chip enable low one cycle before write enable falls. The address does not change from the cycle chip enable falls until the write ends, and output enable stays high throughout.
- R4: During a write the data output enable is high from the fall of chip enable until chip enable rises again. Write enable rises one cycle before chip enable, and the data value does not change in between. The memory therefore captures the requested data.
- R5: Write enable stays low for exactly T_WP cycles in every write.
- R6: A read with the page flag high returns the four words of the page selected by address bits [AW-1:2], in offset order 0, 1, 2, 3. The request's address bits [1:0] are ignored. Only bits [1:0] of the memory address change while chip enable and output enable stay low. The first word is visible T_ACC+1 cycles after acceptance, each later word T_PAGE cycles after the one before, and there is exactly one pulse per word.
- R7: The data output enable is never high while output enable is low.
- R8: Between two operations chip enable stays high for at least T_REC cycles.
- R9: A request is accepted only on a clock edge where both `req_valid_i` and `req_ready_o` are high. `req_ready_o` is low from the cycle after acceptance until the recovery time has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_page_i | input | 1 | 1 = four-word page read (ignored for writes) |
| req_addr_i | input | AW | Word address |
| req_wdata_i | input | DW | Write data |
| rsp_valid_o | output | 1 | One-cycle pulse per returned read word |
| rsp_data_o | output | DW | Returned read word |
| mem_addr_o | output | AW | Memory address bus |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_oe_o | output | 1 | Tri-state enable for `mem_dq_o` |
| mem_dq_i | input | DW | Data returned by the memory |

## Verification
The assertions assume that the host holds its request fields steady while `req_valid_i` is high and not yet accepted. They also assume that the memory drives `mem_dq_i` only while it is selected with output enable low. The bench keeps within these assumptions by raising a request between clock edges and dropping it just after the accepting edge. Its responder returns a poison word unless the strobes and address have been steady for the programmed access or page time. The bench sweeps every address with single reads and writes, and every page with a shifted starting offset. It also checks that each write's captured address and data match the request.

// File: rtl/fbc_pkg.sv
`timescale 1ns/1ps
package fbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACC, ST_RD_PAGE, ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD, ST_RECOVER
  } fbc_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/fbc_timer.sv
`timescale 1ns/1ps
module fbc_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/fbc_seq.sv
`timescale 1ns/1ps
module fbc_seq
  import fbc_pkg::*;
#(
  parameter int T_ACC  = 8,
  parameter int T_PAGE = 3,
  parameter int T_WP   = 5,
  parameter int T_REC  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_write_i,
  input  logic req_page_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic capture_o,
  output logic step_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);
  localparam int MAXC = max4(T_ACC, T_PAGE, T_WP, T_REC);
  localparam int TW   = $clog2(MAXC) + 1;
  localparam logic [TW-1:0] ACC_L  = TW'(T_ACC - 1);
  localparam logic [TW-1:0] PAGE_L = TW'(T_PAGE - 1);
  localparam logic [TW-1:0] WP_L   = TW'(T_WP - 1);
  localparam logic [TW-1:0] REC_L  = TW'(T_REC - 1);

  fbc_state_e    state_q, state_d;
  logic          t_load, t_done;
  logic [TW-1:0] t_val;
  logic [1:0]    word_q;
  logic          page_q;
  logic          ce_q, we_q, oe_q, dqoe_q;

  fbc_timer #(.W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  always_comb begin
    state_d   = state_q;
    t_load    = 1'b0;
    t_val     = '0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    step_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        accept_o = 1'b1;
        if (req_write_i) state_d = ST_WR_SETUP;
        else begin
          state_d = ST_RD_ACC;
          t_load  = 1'b1;
          t_val   = ACC_L;
        end
      end
      ST_RD_ACC, ST_RD_PAGE: if (t_done) begin
        capture_o = 1'b1;
        t_load    = 1'b1;
        if (page_q && !(state_q == ST_RD_PAGE && word_q == 2'd3)) begin
          step_o  = 1'b1;
          state_d = ST_RD_PAGE;
          t_val   = PAGE_L;
        end else begin
          state_d = ST_RECOVER;
          t_val   = REC_L;
        end
      end
      ST_WR_SETUP: begin
        state_d = ST_WR_PULSE;
        t_load  = 1'b1;
        t_val   = WP_L;
      end
      ST_WR_PULSE: if (t_done) state_d = ST_WR_HOLD;
      ST_WR_HOLD: begin
        state_d = ST_RECOVER;
        t_load  = 1'b1;
        t_val   = REC_L;
      end
      ST_RECOVER: if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes registered from the next state so pins change only at clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      dqoe_q  <= 1'b0;
      word_q  <= '0;
      page_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= (state_d == ST_IDLE) || (state_d == ST_RECOVER);
      oe_q    <= !((state_d == ST_RD_ACC) || (state_d == ST_RD_PAGE));
      we_q    <= (state_d != ST_WR_PULSE);
      dqoe_q  <= (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                 (state_d == ST_WR_HOLD);
      if (accept_o) begin
        word_q <= '0;
        page_q <= req_page_i;
      end else if (step_o) begin
        word_q <= word_q + 2'd1;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign ce_no       = ce_q;
  assign we_no       = we_q;
  assign oe_no       = oe_q;
  assign dq_oe_o     = dqoe_q;

  // checker counters for pulse width and recovery window
  logic [TW:0] we_lo_cnt, ce_hi_cnt;
  localparam logic [TW:0] WP_C  = (TW+1)'(T_WP);
  localparam logic [TW:0] REC_C = (TW+1)'(T_REC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      ce_hi_cnt <= REC_C;
    end else begin
      we_lo_cnt <= we_q ? '0 : we_lo_cnt + 1'b1;
      if (!ce_q)                ce_hi_cnt <= '0;
      else if (ce_hi_cnt < REC_C) ce_hi_cnt <= ce_hi_cnt + 1'b1;
    end
  end

  assert_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_no |-> (we_no && oe_no && !dq_oe_o));
  assert_no_contention_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_oe_o && !oe_no));
  assert_we_needs_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> (!ce_no && oe_no));
  assert_we_after_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> $past(!ce_no));
  assert_we_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (!ce_no && dq_oe_o));
  assert_we_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (we_lo_cnt == WP_C));
  assert_ce_recovery_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_no) |-> (ce_hi_cnt >= REC_C));
  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (ce_no && !dq_oe_o));
endmodule

// File: rtl/fbc_datapath.sv
`timescale 1ns/1ps
module fbc_datapath #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          page_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          step_i,
  input  logic          capture_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= dq_i;
      if (accept_i) begin
        addr_q  <= page_i ? {addr_i[AW-1:2], 2'b00} : addr_i;
        wdata_q <= wdata_i;
      end else if (step_i) begin
        addr_q[1:0] <= addr_q[1:0] + 2'd1;
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rvalid_q;
  assign rsp_data_o  = rdata_q;
endmodule

// File: rtl/flash_bus_ctl.sv
`timescale 1ns/1ps
module flash_bus_ctl #(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int T_ACC  = 8,
  parameter int T_PAGE = 3,
  parameter int T_WP   = 5,
  parameter int T_REC  = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_page_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_data_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  if (AW < 3 || T_ACC < 1 || T_PAGE < 1 || T_WP < 1 || T_REC < 1) begin : g_bad_cfg
    $error("flash_bus_ctl: AW must be >= 3 and all wait counts >= 1");
  end

  logic accept, capture, step;

  fbc_seq #(
    .T_ACC (T_ACC),
    .T_PAGE(T_PAGE),
    .T_WP  (T_WP),
    .T_REC (T_REC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_page_i  (req_page_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .capture_o   (capture),
    .step_o      (step),
    .ce_no       (mem_ce_no),
    .we_no       (mem_we_no),
    .oe_no       (mem_oe_no),
    .dq_oe_o     (mem_dq_oe_o)
  );

  fbc_datapath #(
    .AW(AW),
    .DW(DW)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .page_i      (req_page_i && !req_write_i),
    .addr_i      (req_addr_i),
    .wdata_i     (req_wdata_i),
    .step_i      (step),
    .capture_i   (capture),
    .dq_i        (mem_dq_i),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> $stable(mem_addr_o));
  assert_data_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no || $rose(mem_we_no)) |-> $stable(mem_dq_o));
  assert_rsp_after_oe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!mem_oe_no));
  assert_page_upper_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no && $past(!mem_oe_no)) |->
      (mem_addr_o[AW-1:2] == $past(mem_addr_o[AW-1:2])));
endmodule

// File: tb/flash_bus_ctl_test.sv
`timescale 1ns/1ps
module flash_bus_ctl_test;
  localparam int AW = 8, DW = 16, TA = 3, TP = 2, TWP = 3, TR = 2;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_page = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_data, dq_o, dq_i;
  logic [AW-1:0] mem_addr;
  logic          ce_n, we_n, oe_n, dq_oe;

  flash_bus_ctl #(.AW(AW), .DW(DW), .T_ACC(TA), .T_PAGE(TP), .T_WP(TWP), .T_REC(TR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_page_i(req_page), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 16'h0101) ^ 16'h5A3C;
  endfunction

  // behavioural memory: array, access-time model, write latching
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] exp_mem [NW];
  int age = 0, need = TA;
  logic prev_act = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic act, rd_ok;
  assign act   = !ce_n && !oe_n;
  assign rd_ok = act && prev_act && (prev_addr == mem_addr) && (age >= need - 1);
  assign dq_i  = !act ? 16'hEEEE : (rd_ok ? mem[mem_addr] : 16'hBAD0);

  always @(posedge clk) begin
    if (!act) age <= 0;
    else if (!prev_act || mem_addr[AW-1:2] != prev_addr[AW-1:2]) begin age <= 1; need <= TA; end
    else if (mem_addr[1:0] != prev_addr[1:0]) begin age <= 1; need <= TP; end
    else age <= age + 1;
    prev_act  <= act;
    prev_addr <= mem_addr;
  end

  int wr_events, contention, oe_bad, data_bad, lead_bad, rise_bad, standby_bad;
  int we_cnt, last_we_width, ce_hi, min_gap;
  bit seen_fall;
  logic [AW-1:0] wr_addr, last_wr_addr;
  logic [DW-1:0] last_wr_data;
  logic ce_p, we_p;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NW; a++) mem[a] = init_val(a);
      wr_events = 0; contention = 0; oe_bad = 0; data_bad = 0; lead_bad = 0;
      rise_bad = 0; standby_bad = 0; we_cnt = 0; last_we_width = 0; ce_hi = 0;
      min_gap = 1000; seen_fall = 0; ce_p = 1; we_p = 1; wr_addr = '0;
      last_wr_addr = '0; last_wr_data = '0;
    end else begin
      if (dq_oe && !oe_n) contention++;
      if (ce_n && (!we_n || !oe_n || dq_oe)) standby_bad++;
      if (!we_n && !oe_n) oe_bad++;
      if (!ce_n && !we_n && !(!ce_p && !we_p)) wr_addr = mem_addr;
      if (!(!ce_n && !we_n) && (!ce_p && !we_p)) begin
        if (!dq_oe) data_bad++;
        else begin
          mem[wr_addr] = dq_o; wr_events++; last_wr_addr = wr_addr; last_wr_data = dq_o;
        end
      end
      if (!we_n && we_p) begin if (ce_p) lead_bad++; we_cnt = 1; end
      else if (!we_n) we_cnt++;
      if (we_n && !we_p) begin
        last_we_width = we_cnt;
        if (ce_n || !dq_oe) rise_bad++;
      end
      if (ce_n) ce_hi++;
      if (!ce_n && ce_p) begin
        if (seen_fall && ce_hi < min_gap) min_gap = ce_hi;
        seen_fall = 1; ce_hi = 0;
      end
      ce_p = ce_n; we_p = we_n;
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic issue(input logic [AW-1:0] a, input logic w, input logic pg, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_page = pg; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ev0, n;
    ev0 = wr_events;
    issue(a, 1'b1, 1'b0, d);
    @(negedge clk);
    check(!req_ready, "R9 ready low after write accept", int'(req_ready), 0);
    n = 0;
    while (!req_ready && n < 60) begin @(negedge clk); n++; end
    check(wr_events == ev0 + 1, "R4 one captured write", wr_events - ev0, 1);
    check(last_wr_addr == a, "R3 latched write address", int'(last_wr_addr), int'(a));
    check(last_wr_data == d, "R4 latched write data", int'(last_wr_data), int'(d));
    check(last_we_width == TWP, "R5 write enable low width", last_we_width, TWP);
    exp_mem[a] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic pg);
    int nw, got, n, bad, extra, base, expn;
    nw = pg ? 4 : 1;
    base = pg ? int'({a[AW-1:2], 2'b00}) : int'(a);
    got = 0; n = 0; bad = 0; extra = 0;
    issue(a, 1'b0, pg, '0);
    while (got < nw && n < 100) begin
      @(negedge clk); n++;
      if (n == 1) check(!req_ready, "R9 ready low after read accept", int'(req_ready), 0);
      if (rsp_valid) begin
        expn = TA + 1 + got * TP;
        check(n == expn, pg ? "R6 page word latency" : "R2 read latency", n, expn);
        check(rsp_data == exp_mem[base + got], pg ? "R6 page word data" : "R2 read data",
              int'(rsp_data), int'(exp_mem[base + got]));
        got++;
      end else if (ce_n || oe_n || !we_n || mem_addr[AW-1:2] != base[AW-1:2]) bad++;
    end
    check(got == nw, pg ? "R6 page word count" : "R2 read word count", got, nw);
    check(bad == 0, pg ? "R6 strobes and page held" : "R2 strobes held", bad, 0);
    while (!req_ready && extra < 60) begin
      @(negedge clk);
      if (rsp_valid) extra++;
    end
    check(extra == 0, "R6 no extra response pulses", extra, 0);
  endtask

  initial begin
    for (int a = 0; a < NW; a++) exp_mem[a] = init_val(a);
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe, "R1 strobes inactive in reset",
          int'({ce_n, we_n, oe_n, dq_oe}), 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe, "R1 standby after reset",
          int'({ce_n, we_n, oe_n, dq_oe}), 4'b1110);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    check(!rsp_valid, "R1 no response after reset", int'(rsp_valid), 0);

    for (int a = 0; a < NW; a++) do_read(AW'(a), 1'b0);
    for (int a = 0; a < NW; a++) do_write(AW'(a), DW'(a * 16'h03B1 + 16'h0077));
    for (int p = 0; p < NW / 4; p++) do_read(AW'(p * 4 + (p % 4)), 1'b1);
    for (int i = 0; i < 32; i++) begin
      do_write(AW'(i * 7 + 3), DW'(16'hC000 ^ (i * 16'h0123)));
      do_read(AW'(i * 7 + 3), 1'b0);
      do_read(AW'(i * 7 + 3), 1'b1);
    end
    // write request with page flag set behaves as a plain write
    issue(AW'(8'h42), 1'b1, 1'b1, 16'h1357);
    exp_mem[8'h42] = 16'h1357;
    while (!req_ready) @(negedge clk);
    do_read(AW'(8'h42), 1'b0);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(ce_n && we_n && oe_n && !dq_oe && req_ready && !rsp_valid, "R1 idle standby",
            int'({ce_n, we_n, oe_n, dq_oe, req_ready, rsp_valid}), 6'b111010);
    end

    check(contention == 0, "R7 no drive while output enable low", contention, 0);
    check(oe_bad == 0, "R3 output enable high during write", oe_bad, 0);
    check(lead_bad == 0, "R3 chip enable falls before write enable", lead_bad, 0);
    check(rise_bad == 0, "R4 write enable rises first with data driven", rise_bad, 0);
    check(data_bad == 0, "R4 data driven at capture edge", data_bad, 0);
    check(standby_bad == 0, "R1 standby strobes", standby_bad, 0);
    check(min_gap >= TR, "R8 recovery gap", min_gap, TR);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule